// File: doc/BRIEF.md
# OSD Frame Scan and Fade Controller

This block keeps track of where a character overlay stands within a video frame. It counts scan lines between horizontal sync pulses, restarts at every vertical sync, and turns the line position into a glyph dot-line index and a character row count. The row band starts at a programmable vertical position. A character size selector scales the glyph vertically by 1 to 4 scan lines per dot line. It also gives the number of characters that fit on one row for a 12-dot or 16-dot wide glyph matrix.

A one-byte control register is written over a simple write strobe. Its upper nibble holds four settings: pixel-clock source select, double scan, fade enable and display on/off. Its lower nibble reads back the current character row count. Writes to the lower nibble do nothing. In double-scan mode every glyph dot line is shown on two consecutive scan lines, and the programmed start position counts in pairs of lines. With fade enabled, switching the display on or off ramps a 4-bit intensity level by one step per frame. With fade disabled, the display switches at once.

Top module: `osd_frame_ctl`

## Requirements
- R1: After reset the read-back byte is 0x00, the intensity level is 0, display-active is low, the clock-source flag is low, and the dot-line and row outputs are 0.
- R2: A write stores data bits 7..4 as the settings (bit 7 clock source, bit 6 double scan, bit 5 fade enable, bit 4 on/off). Data bits 3..0 are ignored. The read-back byte is {settings, row count}, and the clock-source output follows setting bit 7.
- R3: In single-scan mode, with start line S equal to the 7-bit row position and repeat count N equal to the size selector plus 1, a line that lies K lines after vertical sync shows dot line 0 while K < S and shows dot line ((K−S)/N) mod 16 otherwise.
- R4: In double-scan mode the start line is twice the row position and the repeat count is twice the size selector plus 1. Every dot line then spans twice as many scan lines.
- R5: The row count is ((K−S)/(16·N)) mod 16 once K ≥ S, and 0 before S. It increments as dot line 15 wraps back to 0, and it appears on read-back bits 3..0.
- R6: A vertical sync pulse clears the line position, dot line and row count.
- R7: With fade disabled, the intensity is 15 in the second cycle after the on/off setting is written to 1, and 0 in the second cycle after it is written to 0.
- R8: With fade enabled, every vertical sync moves the intensity one step toward 15 while the display is on and one step toward 0 while it is off, and it stays at the end value. Without a vertical sync the level does not change.
- R9: Display-active is high whenever the on/off setting is 1 or the intensity is nonzero. During a fade-out it therefore falls only when the level reaches 0.
- R10: Flipping the on/off setting partway through a fade reverses the ramp from the level already reached, with no jump.
- R11: Characters per row are 24, 12, 8 and 6 for the 16-dot matrix and 32, 16, 11 and 8 for the 12-dot matrix, for size selector values 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | One-cycle horizontal sync pulse, ends a scan line |
| vsync | input | 1 | One-cycle vertical sync pulse, starts a frame |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Settings nibble over row count nibble |
| row_vpos | input | 7 | Vertical start position of the character rows |
| size_sel | input | 2 | Character scale minus one (1x to 4x) |
| wide_matrix | input | 1 | 1 selects a 16-dot wide glyph, 0 a 12-dot wide glyph |
| pll_clk_sel | output | 1 | Selects the synthesized clock for the pixel logic |
| char_row | output | 4 | Current character row |
| dot_line | output | 4 | Dot line within the current glyph |
| disp_active | output | 1 | Overlay is being displayed |
| fade_level | output | 4 | Display intensity, 0 to 15 |
| chars_per_row | output | 6 | Visible characters per row for the chosen size |

## Verification
Random frames combine the start position, the size selector and the scan mode. Each line's dot and row outputs are compared with a division model, so a wrong repeat count, a start position that is not doubled, or an off-by-one at the start line all give a different result. Directed frames start at line 0 and run past 256 rows of dots, which exposes errors in the row wrap and the status nibble. The fade paths are driven as a full ramp in, a full ramp out, a reversal partway through and an instant toggle, which separate saturation, step direction and the late fall of display-active.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int POS_W   = 7;
  localparam int START_W = POS_W + 1;
  localparam int LVL_W   = 4;
  localparam int SIZE_W  = 2;
  localparam int REP_W   = 4;
  localparam int CPR_W   = 6;

  typedef logic [LVL_W-1:0] level_t;

  // scan lines spent on one glyph dot line
  function automatic logic [REP_W-1:0] lines_per_dot(input logic [SIZE_W-1:0] size,
                                                     input logic dbl);
    logic [REP_W-1:0] r;
    r = REP_W'(size) + REP_W'(1);
    return dbl ? (r << 1) : r;
  endfunction

  // first scan line of the row band
  function automatic logic [START_W-1:0] band_start(input logic [POS_W-1:0] pos,
                                                    input logic dbl);
    return dbl ? {pos, 1'b0} : {1'b0, pos};
  endfunction

  // characters that fit on a row, rounded to nearest
  function automatic logic [CPR_W-1:0] chars_fit(input logic [SIZE_W-1:0] size,
                                                 input logic wide16);
    logic [CPR_W-1:0] base;
    logic [CPR_W-1:0] h;
    base = wide16 ? CPR_W'(24) : CPR_W'(32);
    h    = CPR_W'(size) + CPR_W'(1);
    return (base + (h >> 1)) / h;
  endfunction

  // next intensity level
  function automatic level_t fade_next(input level_t lvl, input logic on,
                                       input logic fade, input logic tick);
    level_t top;
    top = '1;
    if (!fade)              return on ? top : '0;
    if (!tick)              return lvl;
    if (on && lvl != top)   return lvl + level_t'(1);
    if (!on && lvl != '0)   return lvl - level_t'(1);
    return lvl;
  endfunction
endpackage

// File: rtl/osd_line_track.sv
module osd_line_track
  import osd_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int DOT_LINES = 16,
  parameter int ROW_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hsync,
  input  logic                         vsync,
  input  logic [START_W-1:0]           start_line,
  input  logic [REP_W-1:0]             rep,
  output logic [$clog2(DOT_LINES)-1:0] dot_line,
  output logic [ROW_W-1:0]             char_row,
  output logic                         line_step,
  output logic                         row_adv
);
  localparam int DOT_W = $clog2(DOT_LINES);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;
  logic [REP_W-1:0]  sub_q;
  logic [DOT_W-1:0]  dot_q;
  logic [ROW_W-1:0]  row_q;
  logic              in_band;
  logic              sub_last;

  assign in_band   = (line_q >= LINE_W'(start_line));
  assign line_step = hsync & ~vsync & in_band;
  assign sub_last  = (sub_q == rep - REP_W'(1));
  assign row_adv   = line_step & sub_last & (dot_q == DOT_W'(DOT_LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      sub_q  <= '0;
      dot_q  <= '0;
      row_q  <= '0;
    end else if (vsync) begin
      line_q <= '0;
      sub_q  <= '0;
      dot_q  <= '0;
      row_q  <= '0;
    end else if (hsync) begin
      if (line_q != LINE_MAX) line_q <= line_q + LINE_W'(1);
      if (line_step) begin
        if (sub_last) begin
          sub_q <= '0;
          dot_q <= row_adv ? '0 : dot_q + DOT_W'(1);
          if (row_adv) row_q <= row_q + ROW_W'(1);
        end else begin
          sub_q <= sub_q + REP_W'(1);
        end
      end
    end
  end

  assign dot_line = dot_q;
  assign char_row = row_q;
endmodule

// File: rtl/osd_fade_seq.sv
module osd_fade_seq
  import osd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vsync,
  input  logic   fade_en,
  input  logic   disp_on,
  output level_t level,
  output logic   active
);
  level_t level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= fade_next(level_q, disp_on, fade_en, vsync);
  end

  assign level  = level_q;
  assign active = disp_on | (level_q != '0);
endmodule

// File: rtl/osd_frame_ctl.sv
module osd_frame_ctl
  import osd_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int DOT_LINES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [6:0] row_vpos,
  input  logic [1:0] size_sel,
  input  logic       wide_matrix,
  output logic       pll_clk_sel,
  output logic [3:0] char_row,
  output logic [3:0] dot_line,
  output logic       disp_active,
  output logic [3:0] fade_level,
  output logic [5:0] chars_per_row
);
  localparam int ROW_W = 4;

  logic [3:0]         ctrl_q;
  logic               dscan_w;
  logic               fade_en_w;
  logic               disp_on_w;
  logic [START_W-1:0] start_w;
  logic [REP_W-1:0]   rep_w;
  logic               line_step;
  logic               row_adv;
  level_t             level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (reg_wr) ctrl_q <= reg_wdata[7:4];
  end

  assign pll_clk_sel = ctrl_q[3];
  assign dscan_w     = ctrl_q[2];
  assign fade_en_w   = ctrl_q[1];
  assign disp_on_w   = ctrl_q[0];

  assign start_w = band_start(row_vpos, dscan_w);
  assign rep_w   = lines_per_dot(size_sel, dscan_w);

  osd_line_track #(
    .LINE_W   (LINE_W),
    .DOT_LINES(DOT_LINES),
    .ROW_W    (ROW_W)
  ) i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync     (hsync),
    .vsync     (vsync),
    .start_line(start_w),
    .rep       (rep_w),
    .dot_line  (dot_line),
    .char_row  (char_row),
    .line_step (line_step),
    .row_adv   (row_adv)
  );

  osd_fade_seq i_fade (
    .clk    (clk),
    .rst_n  (rst_n),
    .vsync  (vsync),
    .fade_en(fade_en_w),
    .disp_on(disp_on_w),
    .level  (level_w),
    .active (disp_active)
  );

  assign fade_level    = level_w;
  assign reg_rdata     = {ctrl_q, char_row};
  assign chars_per_row = chars_fit(size_sel, wide_matrix);
endmodule

// File: rtl/osd_frame_ctl_chk.sv
module osd_frame_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync,
  input logic       line_step,
  input logic       row_adv,
  input logic       fade_en,
  input logic       disp_on,
  input logic [3:0] fade_level,
  input logic       disp_active,
  input logic [3:0] dot_line,
  input logic [3:0] char_row
);
  AST_VSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (dot_line == 4'd0 && char_row == 4'd0)); // R6

  AST_DOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_step && !vsync) |=> ($stable(dot_line) && $stable(char_row))); // R3

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> (dot_line == 4'd0)); // R5

  AST_INSTANT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!fade_en && disp_on) |=> (fade_level == 4'd15)); // R7

  AST_LEVEL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_en && !vsync) |=> $stable(fade_level)); // R8

  AST_LEVEL_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_en && vsync) |=> (fade_level == $past(fade_level) ||
                            fade_level == $past(fade_level) + 4'd1 ||
                            fade_level == $past(fade_level) - 4'd1)); // R10

  AST_ACTIVE_WHILE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_level != 4'd0) |-> disp_active); // R9
endmodule

bind osd_frame_ctl osd_frame_ctl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync      (vsync),
  .line_step  (line_step),
  .row_adv    (row_adv),
  .fade_en    (fade_en_w),
  .disp_on    (disp_on_w),
  .fade_level (fade_level),
  .disp_active(disp_active),
  .dot_line   (dot_line),
  .char_row   (char_row)
);

// File: tb/test_osd_frame_ctl.sv
`timescale 1ns/1ps
module test_osd_frame_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic       vsync = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [6:0] row_vpos = 7'd0;
  logic [1:0] size_sel = 2'd0;
  logic       wide_matrix = 1'b0;
  logic       pll_clk_sel;
  logic [3:0] char_row;
  logic [3:0] dot_line;
  logic       disp_active;
  logic [3:0] fade_level;
  logic [5:0] chars_per_row;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  osd_frame_ctl i_osd_frame_ctl (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .row_vpos(row_vpos), .size_sel(size_sel), .wide_matrix(wide_matrix),
    .pll_clk_sel(pll_clk_sel), .char_row(char_row), .dot_line(dot_line),
    .disp_active(disp_active), .fade_level(fade_level),
    .chars_per_row(chars_per_row)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int m_dot(int k, int s, int n);
    if (k < s) return 0;
    return ((k - s) / n) % 16;
  endfunction

  function automatic int m_row(int k, int s, int n);
    if (k < s) return 0;
    return ((k - s) / (n * 16)) % 16;
  endfunction

  function automatic int m_chars(int size, bit wide);
    int t16[4] = '{24, 12, 8, 6};
    int t12[4] = '{32, 16, 11, 8};
    return wide ? t16[size] : t12[size];
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic vpulse();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic hpulse();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
  endtask

  task automatic run_frame(input bit dbl, input int pos, input int size,
                           input int nlines);
    int s;
    int n;
    s = dbl ? 2 * pos : pos;
    n = (size + 1) * (dbl ? 2 : 1);
    row_vpos = 7'(pos);
    size_sel = 2'(size);
    vpulse();
    chk(dot_line, 0, "R6 dot after vsync");
    chk(char_row, 0, "R6 row after vsync");
    for (int k = 1; k <= nlines; k++) begin
      hpulse();
      chk(dot_line, m_dot(k, s, n), dbl ? "R4 dot double scan" : "R3 dot single scan");
      chk(char_row, m_row(k, s, n), "R5 row count");
      chk(reg_rdata[3:0], m_row(k, s, n), "R5 status nibble");
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int lvl;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata, 0, "R1 rdata");
    chk(fade_level, 0, "R1 level");
    chk(disp_active, 0, "R1 active");
    chk(pll_clk_sel, 0, "R1 pll flag");
    chk(dot_line, 0, "R1 dot");
    chk(char_row, 0, "R1 row");
    rst_n = 1'b1;
    @(negedge clk);

    // R7 instant switching
    wr(8'h10);
    @(negedge clk);
    chk(fade_level, 15, "R7 instant on");
    chk(disp_active, 1, "R9 active when on");
    wr(8'h00);
    @(negedge clk);
    chk(fade_level, 0, "R7 instant off");
    chk(disp_active, 0, "R9 inactive when off");

    // R8 fade in and saturation
    wr(8'h30);
    @(negedge clk);
    chk(fade_level, 0, "R8 no step without vsync");
    chk(disp_active, 1, "R9 active at fade start");
    for (int i = 1; i <= 16; i++) begin
      vpulse();
      chk(fade_level, (i > 15) ? 15 : i, "R8 fade in step");
    end
    // R10 reversal partway
    wr(8'h20);
    for (int i = 1; i <= 5; i++) vpulse();
    chk(fade_level, 10, "R10 partial fade out");
    wr(8'h30);
    vpulse();
    chk(fade_level, 11, "R10 reversed to fade in");
    wr(8'h20);
    lvl = 11;
    for (int i = 0; i < 12; i++) begin
      vpulse();
      lvl = (lvl > 0) ? lvl - 1 : 0;
      chk(fade_level, lvl, "R8 fade out step");
      chk(disp_active, (lvl != 0) ? 1 : 0, "R9 active until level zero");
    end

    // R2 register write, low nibble ignored
    wr(8'h00);
    vpulse();
    wr(8'hCF);
    chk(reg_rdata, 8'hC0, "R2 readback ignores low nibble");
    chk(pll_clk_sel, 1, "R2 clock-source flag");
    wr(8'h05);
    chk(reg_rdata, 8'h00, "R2 readback after clear");
    chk(pll_clk_sel, 0, "R2 clock-source flag clear");

    // R11 characters per row
    for (int w = 0; w < 2; w++) begin
      for (int sz = 0; sz < 4; sz++) begin
        wide_matrix = w[0];
        size_sel = 2'(sz);
        #1;
        chk(chars_per_row, m_chars(sz, w[0]), "R11 chars per row");
      end
    end

    // directed: start at line 0, long frame with row wrap
    wr(8'h00);
    run_frame(1'b0, 0, 0, 270);
    wr(8'h40);
    run_frame(1'b1, 0, 0, 40);
    run_frame(1'b1, 3, 3, 90);

    // random frames
    for (int f = 0; f < 12; f++) begin
      bit dbl;
      int pos;
      int sz;
      int n;
      dbl = 1'($urandom % 2);
      pos = $urandom % 21;
      sz = $urandom % 4;
      b = 8'($urandom);
      b[6] = dbl;
      wr(b);
      chk(reg_rdata[7:4], b[7:4], "R2 random settings");
      n = (sz + 1) * (dbl ? 2 : 1);
      run_frame(dbl, pos, sz, (dbl ? 2 * pos : pos) + n * 32 + int'($urandom % 20));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule